// File: doc/BRIEF.md
# Halfword Load Unit with Split Instruction/Data Caches

This unit answers halfword read requests from a small processor core. Each request carries a virtual address, a physical address, a cacheable flag and an access kind (instruction or data). Two cache-control inputs change how the lookup behaves. One swaps the roles of the two caches. The other isolates the caches, so that every lookup is reported as a hit. The unit keeps two direct-mapped caches, one for instructions and one for data. Each line holds one 32-bit word, a 30-bit tag and a valid bit.

A request first has its alignment checked. A cacheable request then looks up the selected cache and, on a hit, returns the addressed halfword one cycle later. A miss or an uncacheable request goes to memory. The physical address is decoded into a RAM, ROM or console window, and a held read request goes out with a region code and an offset inside that window. The result comes back once memory answers. An odd address, or an address outside every window, ends the request with an address-error-on-load indication.

An external refill engine writes cache lines through a single fill port. The unit never writes lines on its own.

Top module: `hwl_halfword_load`

## Requirements
- R1: A request whose physical address has bit 0 set finishes in the following cycle with `done`=1 and `err`=1. No memory request is raised.
- R2: A cacheable request hits when the line at index `paddr[5:2]` is valid and its stored tag equals `vaddr[31:2]`. On a hit, `done`=1 and `err`=0 in the next cycle and no memory request is raised.
- R3: On a hit, `vaddr[1]`=0 returns bits [31:16] of the line word and `vaddr[1]`=1 returns bits [15:0].
- R4: With swap off, `is_instr`=1 looks up the instruction cache and `is_instr`=0 looks up the data cache.
- R5: With `swap_caches`=1, an instruction access looks up the data cache and a data access looks up the instruction cache.
- R6: With `isolate_caches`=1, every cacheable lookup hits and returns the indexed line's word, whatever its tag holds.
- R7: A miss or an uncacheable request raises `mem_req` in the next cycle. The region code is 0 for RAM (paddr <= RAM_TOP, offset paddr-RAM_BASE), 1 for ROM (ROM_BASE..ROM_TOP, offset paddr-ROM_BASE) and 2 for console (CON_BASE..CON_TOP, offset paddr-CON_BASE).
- R8: `mem_req`, `mem_region` and `mem_offset` stay unchanged until `mem_rvalid` is sampled. In the next cycle `mem_req` falls and a one-cycle `done` returns `{mem_rbyte0, mem_rbyte1}`: the byte at the lower address forms the upper half.
- R9: An aligned request that does not hit and whose physical address lies in no window finishes in the next cycle with `err`=1. No memory request is raised.
- R10: Reset clears `done`, `err` and `mem_req` and invalidates every line, so the first cacheable lookup after reset misses.
- R11: A fill writes tag and word into the chosen cache at `fill_index` and marks that line valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start a halfword load (ignored while a memory read is pending) |
| vaddr | input | 32 | Virtual address (tag and halfword select) |
| paddr | input | 32 | Physical address (index, alignment, region) |
| cacheable | input | 1 | Access may be served from a cache |
| is_instr | input | 1 | 1 = instruction access, 0 = data access |
| swap_caches | input | 1 | Exchange instruction and data cache roles |
| isolate_caches | input | 1 | Force every lookup to hit |
| fill_en | input | 1 | Write one cache line |
| fill_icache | input | 1 | 1 = fill instruction cache, 0 = data cache |
| fill_index | input | 4 | Line to fill |
| fill_tag | input | 30 | Tag to store |
| fill_word | input | 32 | Word to store |
| mem_req | output | 1 | Memory read pending |
| mem_region | output | 2 | Region code of the pending read |
| mem_offset | output | 32 | Offset inside the region |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rbyte0 | input | 8 | Byte at the offset |
| mem_rbyte1 | input | 8 | Byte at offset+1 |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Address error on load, valid with done |
| rdata | output | 16 | Loaded halfword, valid with done |

## Verification
The assertions assume three things about the inputs. The RAM, ROM and console windows given as parameters do not overlap. `mem_rvalid` is only raised while a read is pending. A new request is not started while the unit waits on memory. The bench meets all three. It keeps the default windows and raises `mem_rvalid` only after it has seen `mem_req` high. Each scenario task also waits for `done` before it issues the next request.

// File: rtl/hwl_pkg.sv
package hwl_pkg;
  typedef enum logic [1:0] {
    RGN_RAM  = 2'd0,
    RGN_ROM  = 2'd1,
    RGN_CON  = 2'd2,
    RGN_NONE = 2'd3
  } region_e;

  typedef enum logic {
    ST_IDLE,
    ST_MEM
  } state_e;
endpackage

// File: rtl/hwl_line_store.sv
module hwl_line_store #(
  parameter int LINES  = 16,
  parameter int TAG_W  = 30,
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic              isolate,
  output logic              hit,
  output logic [WORD_W-1:0] rd_word
);
  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_mem  [LINES];
  logic [WORD_W-1:0] word_mem [LINES];

  // valid bits need reset, so they live in flops
  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  // tag and word arrays carry no reset, so they can map to distributed RAM
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      word_mem[wr_idx] <= wr_word;
    end
  end

  assign rd_word = word_mem[rd_idx];
  assign hit     = isolate | (valid_q[rd_idx] & (tag_mem[rd_idx] == rd_tag));

  // R11: a fill leaves its line valid
  a_r11_fill_sets_valid: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/hwl_region_map.sv
module hwl_region_map
  import hwl_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] RAM_BASE = 32'h0000_0000,
  parameter logic [31:0] RAM_TOP  = 32'h003F_FFFF,
  parameter logic [31:0] ROM_BASE = 32'h1FC0_0000,
  parameter logic [31:0] ROM_TOP  = 32'h1FC7_FFFF,
  parameter logic [31:0] CON_BASE = 32'h1FD0_0000,
  parameter logic [31:0] CON_TOP  = 32'h1FD0_00FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [ADDR_W-1:0] offset
);
  logic in_ram, in_rom, in_con;

  // RAM has only an upper limit: everything below it belongs to RAM
  assign in_ram = (addr <= RAM_TOP[ADDR_W-1:0]);
  assign in_rom = (addr >= ROM_BASE[ADDR_W-1:0]) && (addr <= ROM_TOP[ADDR_W-1:0]);
  assign in_con = (addr >= CON_BASE[ADDR_W-1:0]) && (addr <= CON_TOP[ADDR_W-1:0]);

  always_comb begin
    region = RGN_NONE;
    offset = '0;
    if (in_ram) begin
      region = RGN_RAM;
      offset = addr - RAM_BASE[ADDR_W-1:0];
    end else if (in_rom) begin
      region = RGN_ROM;
      offset = addr - ROM_BASE[ADDR_W-1:0];
    end else if (in_con) begin
      region = RGN_CON;
      offset = addr - CON_BASE[ADDR_W-1:0];
    end
  end

  // R7: windows must not overlap, so at most one claims an address
  a_r7_windows_disjoint: assert property (@(posedge clk) disable iff (rst)
    $onehot0({in_ram, in_rom, in_con}));
endmodule

// File: rtl/hwl_halfword_load.sv
module hwl_halfword_load
  import hwl_pkg::*;
#(
  parameter int          LINES    = 16,
  parameter logic [31:0] RAM_BASE = 32'h0000_0000,
  parameter logic [31:0] RAM_TOP  = 32'h003F_FFFF,
  parameter logic [31:0] ROM_BASE = 32'h1FC0_0000,
  parameter logic [31:0] ROM_TOP  = 32'h1FC7_FFFF,
  parameter logic [31:0] CON_BASE = 32'h1FD0_0000,
  parameter logic [31:0] CON_TOP  = 32'h1FD0_00FF,
  localparam int ADDR_W = 32,
  localparam int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W,
  localparam int TAG_W  = ADDR_W - 2,
  localparam int IDX_W  = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [ADDR_W-1:0] paddr,
  input  logic              cacheable,
  input  logic              is_instr,
  input  logic              swap_caches,
  input  logic              isolate_caches,
  input  logic              fill_en,
  input  logic              fill_icache,
  input  logic [IDX_W-1:0]  fill_index,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [WORD_W-1:0] fill_word,
  output logic              mem_req,
  output logic [1:0]        mem_region,
  output logic [ADDR_W-1:0] mem_offset,
  input  logic              mem_rvalid,
  input  logic [7:0]        mem_rbyte0,
  input  logic [7:0]        mem_rbyte1,
  output logic              done,
  output logic              err,
  output logic [HALF_W-1:0] rdata
);
  logic [1:0]        bank_hit;
  logic [WORD_W-1:0] bank_word [2];
  logic              sel_icache;
  logic              lk_hit;
  logic [WORD_W-1:0] lk_word;
  logic [HALF_W-1:0] lk_half;
  region_e           rgn;
  logic [ADDR_W-1:0] rgn_off;
  state_e            state_q;
  logic              done_q, err_q, mem_req_q;
  logic [HALF_W-1:0] data_q;
  region_e           region_q;
  logic [ADDR_W-1:0] offset_q;
  logic              take;

  // bank 0 = data cache, bank 1 = instruction cache
  for (genvar b = 0; b < 2; b++) begin : g_bank
    hwl_line_store #(.LINES(LINES), .TAG_W(TAG_W), .WORD_W(WORD_W)) u_store (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (fill_en && (fill_icache == (b == 1))),
      .wr_idx  (fill_index),
      .wr_tag  (fill_tag),
      .wr_word (fill_word),
      .rd_idx  (paddr[IDX_W+1:2]),
      .rd_tag  (vaddr[ADDR_W-1:2]),
      .isolate (isolate_caches),
      .hit     (bank_hit[b]),
      .rd_word (bank_word[b])
    );
  end

  assign sel_icache = is_instr ^ swap_caches;
  assign lk_hit     = bank_hit[sel_icache];
  assign lk_word    = bank_word[sel_icache];
  assign lk_half    = vaddr[1] ? lk_word[HALF_W-1:0] : lk_word[WORD_W-1:HALF_W];

  hwl_region_map #(
    .ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE), .RAM_TOP(RAM_TOP),
    .ROM_BASE(ROM_BASE), .ROM_TOP(ROM_TOP), .CON_BASE(CON_BASE), .CON_TOP(CON_TOP)
  ) u_map (
    .clk    (clk),
    .rst    (rst),
    .addr   (paddr),
    .region (rgn),
    .offset (rgn_off)
  );

  assign take = req && (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      data_q    <= '0;
      mem_req_q <= 1'b0;
      region_q  <= RGN_RAM;
      offset_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req) begin
          if (paddr[0]) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
            data_q <= '0;
          end else if (cacheable && lk_hit) begin
            done_q <= 1'b1;
            data_q <= lk_half;
          end else if (rgn == RGN_NONE) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
            data_q <= '0;
          end else begin
            mem_req_q <= 1'b1;
            region_q  <= rgn;
            offset_q  <= rgn_off;
            state_q   <= ST_MEM;
          end
        end
        ST_MEM: if (mem_rvalid) begin
          mem_req_q <= 1'b0;
          done_q    <= 1'b1;
          data_q    <= {mem_rbyte0, mem_rbyte1};
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req    = mem_req_q;
  assign mem_region = region_q;
  assign mem_offset = offset_q;
  assign done       = done_q;
  assign err        = err_q;
  assign rdata      = data_q;

  // R1: odd address ends with an error and never reaches memory
  a_r1_odd_addr_error: assert property (@(posedge clk) disable iff (rst)
    take && paddr[0] |=> done_q && err_q && !mem_req_q);

  // R2: a hit completes next cycle without a memory read
  a_r2_hit_no_memory: assert property (@(posedge clk) disable iff (rst)
    take && !paddr[0] && cacheable && lk_hit |=> done_q && !err_q && !mem_req_q);

  // R8: pending read holds its region and offset
  a_r8_request_held: assert property (@(posedge clk) disable iff (rst)
    mem_req_q && !mem_rvalid |=> mem_req_q && $stable(offset_q) && $stable(region_q));

  // R8: completion and a pending read never overlap
  a_r8_done_clears_req: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !mem_req_q);

  // R9: unmapped miss ends in an error
  a_r9_unmapped_error: assert property (@(posedge clk) disable iff (rst)
    take && !paddr[0] && !(cacheable && lk_hit) && (rgn == RGN_NONE)
      |=> done_q && err_q && !mem_req_q);
endmodule

// File: tb/sim_hwl_halfword_load.sv
module sim_hwl_halfword_load;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [31:0] vaddr = '0, paddr = '0;
  logic        cacheable = 1'b0, is_instr = 1'b0, swap_caches = 1'b0, isolate_caches = 1'b0;
  logic        fill_en = 1'b0, fill_icache = 1'b0;
  logic [3:0]  fill_index = '0;
  logic [29:0] fill_tag = '0;
  logic [31:0] fill_word = '0;
  logic        mem_req;
  logic [1:0]  mem_region;
  logic [31:0] mem_offset;
  logic        mem_rvalid = 1'b0;
  logic [7:0]  mem_rbyte0 = '0, mem_rbyte1 = '0;
  logic        done, err;
  logic [15:0] rdata;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hwl_halfword_load u0 (
    .clk(clk), .rst(rst), .req(req), .vaddr(vaddr), .paddr(paddr),
    .cacheable(cacheable), .is_instr(is_instr), .swap_caches(swap_caches),
    .isolate_caches(isolate_caches), .fill_en(fill_en), .fill_icache(fill_icache),
    .fill_index(fill_index), .fill_tag(fill_tag), .fill_word(fill_word),
    .mem_req(mem_req), .mem_region(mem_region), .mem_offset(mem_offset),
    .mem_rvalid(mem_rvalid), .mem_rbyte0(mem_rbyte0), .mem_rbyte1(mem_rbyte1),
    .done(done), .err(err), .rdata(rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic fill(input logic icache, input logic [3:0] idx, input logic [31:0] va,
                      input logic [31:0] word);
    @(negedge clk);
    fill_en = 1'b1; fill_icache = icache; fill_index = idx;
    fill_tag = va[31:2]; fill_word = word;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  // issue one request; returns at the negedge after the sampling edge
  task automatic issue(input logic [31:0] va, input logic [31:0] pa, input logic cach,
                       input logic instr, input logic swp, input logic iso);
    @(negedge clk);
    req = 1'b1; vaddr = va; paddr = pa; cacheable = cach;
    is_instr = instr; swap_caches = swp; isolate_caches = iso;
    @(negedge clk);
    req = 1'b0; swap_caches = 1'b0; isolate_caches = 1'b0;
  endtask

  task automatic expect_hit(input string tag, input logic [15:0] exp);
    chk({tag, " done"}, done, 1);
    chk({tag, " err"}, err, 0);
    chk({tag, " data"}, rdata, exp);
    chk({tag, " no mem_req"}, mem_req, 0);
    @(negedge clk);
    chk({tag, " done one cycle"}, done, 0);
  endtask

  task automatic expect_err(input string tag);
    chk({tag, " done"}, done, 1);
    chk({tag, " err"}, err, 1);
    chk({tag, " no mem_req"}, mem_req, 0);
    @(negedge clk);
    chk({tag, " no later mem_req"}, mem_req, 0);
  endtask

  task automatic expect_mem(input string tag, input logic [1:0] rg, input logic [31:0] off,
                            input logic [7:0] b0, input logic [7:0] b1);
    chk({tag, " mem_req"}, mem_req, 1);
    chk({tag, " not done"}, done, 0);
    chk({tag, " region"}, mem_region, rg);
    chk({tag, " offset"}, mem_offset, off);
    repeat (2) @(negedge clk);
    chk({tag, " R8 held req"}, mem_req, 1);
    chk({tag, " R8 held offset"}, mem_offset, off);
    mem_rvalid = 1'b1; mem_rbyte0 = b0; mem_rbyte1 = b1;
    @(negedge clk);
    mem_rvalid = 1'b0;
    chk({tag, " R8 done"}, done, 1);
    chk({tag, " R8 err"}, err, 0);
    chk({tag, " R8 big-endian data"}, rdata, {16'h0, b0, b1});
    chk({tag, " R8 req dropped"}, mem_req, 0);
  endtask

  task automatic t_reset();
    chk("R10 done after reset", done, 0);
    chk("R10 err after reset", err, 0);
    chk("R10 mem_req after reset", mem_req, 0);
    // isolate off: an unfilled line must miss
    issue(32'h8000_0010, 32'h0000_0010, 1, 0, 0, 0);
    expect_mem("R10 cold miss", 2'd0, 32'h10, 8'h01, 8'h02);
  endtask

  task automatic t_data_hit();
    fill(0, 4'd3, 32'h8000_000C, 32'hAABB_CCDD);
    issue(32'h8000_000C, 32'h0000_000C, 1, 0, 0, 0);
    expect_hit("R2 R3 R11 dcache upper half", 16'hAABB);
    issue(32'h8000_000E, 32'h0000_000E, 1, 0, 0, 0);
    expect_hit("R3 dcache lower half", 16'hCCDD);
  endtask

  task automatic t_instr_hit();
    fill(1, 4'd3, 32'h8000_000C, 32'h1122_3344);
    issue(32'h8000_000C, 32'h0000_000C, 1, 1, 0, 0);
    expect_hit("R4 icache lookup", 16'h1122);
    issue(32'h8000_000C, 32'h0000_000C, 1, 0, 0, 0);
    expect_hit("R4 dcache still separate", 16'hAABB);
  endtask

  task automatic t_swap();
    issue(32'h8000_000C, 32'h0000_000C, 1, 0, 1, 0);
    expect_hit("R5 data access uses icache", 16'h1122);
    issue(32'h8000_000E, 32'h0000_000E, 1, 1, 1, 0);
    expect_hit("R5 instr access uses dcache", 16'hCCDD);
  endtask

  task automatic t_isolate_and_miss();
    fill(0, 4'd9, 32'h0000_1234, 32'h5566_7788);
    issue(32'h4000_0026, 32'h0000_0026, 1, 0, 0, 1);
    expect_hit("R6 isolate forces hit", 16'h7788);
    issue(32'h4000_0024, 32'h0000_0024, 1, 0, 0, 0);
    expect_mem("R7 tag miss goes to RAM", 2'd0, 32'h24, 8'h9A, 8'hBC);
  endtask

  task automatic t_uncached();
    issue(32'h8000_000C, 32'h0000_000C, 0, 0, 0, 0);
    expect_mem("R7 uncached bypasses hit", 2'd0, 32'h0C, 8'hDE, 8'hAD);
    issue(32'h9FC0_0010, 32'h1FC0_0010, 1, 1, 0, 0);
    expect_mem("R7 ROM window", 2'd1, 32'h10, 8'h3C, 8'h08);
    issue(32'hBFD0_0006, 32'h1FD0_0006, 0, 0, 0, 0);
    expect_mem("R7 console window", 2'd2, 32'h06, 8'h00, 8'h41);
  endtask

  task automatic t_misalign();
    issue(32'h8000_000D, 32'h0000_000D, 1, 0, 0, 1);
    expect_err("R1 odd address");
  endtask

  task automatic t_unmapped();
    issue(32'h1000_0000, 32'h1000_0000, 0, 0, 0, 0);
    expect_err("R9 unmapped uncached");
    issue(32'h1000_0004, 32'h1000_0004, 1, 0, 0, 0);
    expect_err("R9 unmapped cacheable miss");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_data_hit();
    t_instr_hit();
    t_swap();
    t_isolate_and_miss();
    t_uncached();
    t_misalign();
    t_unmapped();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule